// File: doc/BRIEF.md
# Board Control Register Bank

A bank of board-level control registers behind a simple 32-bit memory-mapped bus with separate read and write strobes, a byte address and 32-bit write and read data. Software uses it to drive an eight-lamp LED bar and an eight-character text display, to keep a few scratch bytes, to ask the system for a reset, and to toggle two wires that bit-bang a serial EEPROM.

The display can be loaded two ways. One word write turns a 32-bit value into eight uppercase hexadecimal ASCII digits. Separate byte writes place single characters. The EEPROM wires follow each write to the I2C output register at once. The EEPROM's data line comes back in bit 0 of the I2C input register.

Reads are registered. Read data appears on the cycle after the read strobe and is zero on any cycle that follows no read. A parameter selects the byte-order flag reported in the status word.

Top module: `board_ctrl_regs`

## Requirements
- R1: Only address bits 19:0 are decoded, so 0xFFF00408 reaches the same register as 0x408. Reads are registered: bus_rdata carries the value on the cycle after bus_rd is high, and is zero on the cycle after bus_rd is low. Unmapped offsets read zero, and writes to them change no register or output.
- R2: Offset 0x200 and offset 0x210 read zero. Offset 0x208 reads 0x12 when BIG_ENDIAN is 1 and 0x10 when it is 0.
- R3: A write to 0x408 stores write data bits 7:0. The stored byte drives led_bar and reads back at 0x408 with bits 31:8 zero.
- R4: A write to 0x410 sets all eight display characters. Character k, which is disp_chars[8k+7:8k], becomes the uppercase ASCII hex digit of data nibble 7-k. So character 0 holds the most significant nibble. Digits 0-9 map to 0x30-0x39 and A-F map to 0x41-0x46.
- R5: A write to 0x418 + 8k, for k from 0 to 7, sets character k to write data bits 7:0 and leaves the other characters unchanged.
- R6: A write of exactly 0x00000042 to 0x500 makes sys_reset_req high for the one cycle after the write. Any other value at 0x500 leaves it low.
- R7: Offsets 0x508 and 0xA00 each store 8 bits and read them back. Offset 0xB08 stores bits 1:0 and reads them back.
- R8: A write to 0xB10 stores the full 32-bit value, which reads back at 0xB10. Bit 1 of that value drives i2c_scl and bit 0 drives i2c_sda. A read of 0xB00 returns 0x2 with bit 0 replaced by eeprom_sda_in.
- R9: Offset 0xB18 stores a 1-bit select. A read of 0xA08 returns the 0xB10 value when the select is 1, and zero when it is 0.
- R10: After reset the registers and outputs hold these values: LED 0x00, break 0x0A, general output 0x00, output enable 0x0, I2C output 0x3 (so i2c_scl and i2c_sda are both 1), select 0x1, every display character 0x20, and sys_reset_req 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| led_bar | output | 8 | LED bar pattern |
| disp_chars | output | 64 | Display characters, character k in bits 8k+7:8k |
| sys_reset_req | output | 1 | One-cycle system reset request |
| i2c_scl | output | 1 | Clock level toward the EEPROM |
| i2c_sda | output | 1 | Data level toward the EEPROM |
| eeprom_sda_in | input | 1 | Data level from the EEPROM |

## Verification
Every stored register is either read back over the bus or drives a pin directly. A corrupted value therefore shows at led_bar, disp_chars or the I2C pins on the cycle after the write that caused it. Otherwise it shows in bus_rdata one cycle after the next read. A wrong decode of a display offset puts its byte in the wrong character of disp_chars. That is visible at once, because the bench compares all 64 bits after every display write. A stuck or stretched reset request shows within two cycles of the magic write.

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs #(
  parameter bit          BIG_ENDIAN = 1'b1,
  parameter int          DW         = 32,
  parameter int          AW         = 32,
  parameter int          DEC_BITS   = 20,
  parameter int          NCHAR      = 8,
  parameter logic [31:0] RESET_KEY  = 32'h42
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [AW-1:0]       bus_addr,
  input  logic [DW-1:0]       bus_wdata,
  output logic [DW-1:0]       bus_rdata,
  output logic [7:0]          led_bar,
  output logic [NCHAR*8-1:0]  disp_chars,
  output logic                sys_reset_req,
  output logic                i2c_scl,
  output logic                i2c_sda,
  input  logic                eeprom_sda_in
);
  localparam logic [DEC_BITS-1:0] OFS_SWITCH = DEC_BITS'('h200);
  localparam logic [DEC_BITS-1:0] OFS_STATUS = DEC_BITS'('h208);
  localparam logic [DEC_BITS-1:0] OFS_JUMPER = DEC_BITS'('h210);
  localparam logic [DEC_BITS-1:0] OFS_LED    = DEC_BITS'('h408);
  localparam logic [DEC_BITS-1:0] OFS_HEXWRD = DEC_BITS'('h410);
  localparam logic [DEC_BITS-1:0] OFS_CHAR0  = DEC_BITS'('h418);
  localparam logic [DEC_BITS-1:0] OFS_SWRST  = DEC_BITS'('h500);
  localparam logic [DEC_BITS-1:0] OFS_BREAK  = DEC_BITS'('h508);
  localparam logic [DEC_BITS-1:0] OFS_GPOUT  = DEC_BITS'('hA00);
  localparam logic [DEC_BITS-1:0] OFS_GPIN   = DEC_BITS'('hA08);
  localparam logic [DEC_BITS-1:0] OFS_I2CIN  = DEC_BITS'('hB00);
  localparam logic [DEC_BITS-1:0] OFS_I2COE  = DEC_BITS'('hB08);
  localparam logic [DEC_BITS-1:0] OFS_I2COUT = DEC_BITS'('hB10);
  localparam logic [DEC_BITS-1:0] OFS_I2CSEL = DEC_BITS'('hB18);
  localparam logic [DW-1:0]       STATUS_VAL = BIG_ENDIAN ? DW'('h12) : DW'('h10);
  localparam logic [DW-1:0]       I2CIN_RST  = DW'('h3);

  logic [DEC_BITS-1:0] ofs;
  logic [7:0]          brk_q, gpo_q;
  logic [1:0]          oe_q;
  logic                sel_q;
  logic [DW-1:0]       i2co_q, rd_val;
  logic                wr_hex;

  assign ofs    = bus_addr[DEC_BITS-1:0];
  assign wr_hex = bus_wr && ofs == OFS_HEXWRD;

  function automatic logic [7:0] hex_ascii(input logic [3:0] n);
    return (n < 4'd10) ? (8'h30 + {4'd0, n}) : (8'h37 + {4'd0, n});
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_bar       <= 8'h00;
      brk_q         <= 8'h0A;
      gpo_q         <= 8'h00;
      oe_q          <= 2'b00;
      i2co_q        <= DW'('h3);
      sel_q         <= 1'b1;
      sys_reset_req <= 1'b0;
    end else begin
      sys_reset_req <= bus_wr && ofs == OFS_SWRST && bus_wdata == RESET_KEY;
      if (bus_wr) begin
        case (ofs)
          OFS_LED:    led_bar <= bus_wdata[7:0];
          OFS_BREAK:  brk_q   <= bus_wdata[7:0];
          OFS_GPOUT:  gpo_q   <= bus_wdata[7:0];
          OFS_I2COE:  oe_q    <= bus_wdata[1:0];
          OFS_I2COUT: i2co_q  <= bus_wdata;
          OFS_I2CSEL: sel_q   <= bus_wdata[0];
          default: ;
        endcase
      end
    end
  end

  assign i2c_scl = i2co_q[1];
  assign i2c_sda = i2co_q[0];

  for (genvar k = 0; k < NCHAR; k++) begin : g_char
    logic wr_one;
    assign wr_one = bus_wr && ofs == OFS_CHAR0 + DEC_BITS'(8 * k);
    always_ff @(posedge clk) begin
      if (!rst_n)       disp_chars[8*k +: 8] <= 8'h20;
      else if (wr_hex)  disp_chars[8*k +: 8] <= hex_ascii(bus_wdata[4*(NCHAR-1-k) +: 4]);
      else if (wr_one)  disp_chars[8*k +: 8] <= bus_wdata[7:0];
    end
  end

  always_comb begin
    rd_val = '0;
    case (ofs)
      OFS_SWITCH: rd_val = '0;
      OFS_STATUS: rd_val = STATUS_VAL;
      OFS_JUMPER: rd_val = '0;
      OFS_LED:    rd_val = {{(DW-8){1'b0}}, led_bar};
      OFS_BREAK:  rd_val = {{(DW-8){1'b0}}, brk_q};
      OFS_GPOUT:  rd_val = {{(DW-8){1'b0}}, gpo_q};
      OFS_GPIN:   rd_val = sel_q ? i2co_q : '0;
      OFS_I2CIN:  rd_val = {I2CIN_RST[DW-1:1], eeprom_sda_in};
      OFS_I2COE:  rd_val = {{(DW-2){1'b0}}, oe_q};
      OFS_I2COUT: rd_val = i2co_q;
      OFS_I2CSEL: rd_val = {{(DW-1){1'b0}}, sel_q};
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
    else             bus_rdata <= '0;
  end

  p_idle_rdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bus_rd) |-> bus_rdata == '0);
  p_led_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bus_wr) |-> $stable(led_bar));
  p_disp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bus_wr) |-> $stable(disp_chars));
  p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |-> $past(bus_wr) && $past(bus_wdata) == RESET_KEY);
  p_pins_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!bus_wr) |-> $stable({i2c_scl, i2c_sda}));
endmodule

// File: tb/board_ctrl_regs_bench.sv
module board_ctrl_regs_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, eeprom_sda_in = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic [7:0]  led_bar;
  logic [63:0] disp_chars;
  logic        sys_reset_req, i2c_scl, i2c_sda;
  int          n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  board_ctrl_regs u_board_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .led_bar(led_bar), .disp_chars(disp_chars), .sys_reset_req(sys_reset_req),
    .i2c_scl(i2c_scl), .i2c_sda(i2c_sda), .eeprom_sda_in(eeprom_sda_in));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [31:0] a, input logic [31:0] exp);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    check(req, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  function automatic logic [7:0] asc(input int n);
    return (n < 10) ? 8'(48 + n) : 8'(55 + n);
  endfunction

  function automatic logic [63:0] hexdisp(input logic [31:0] v);
    logic [63:0] r;
    for (int k = 0; k < 8; k++) r[8*k +: 8] = asc(int'((v >> (28 - 4*k)) & 32'hF));
    return r;
  endfunction

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] exp_disp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 led", {56'd0, led_bar}, 64'h0);
    check("R10 disp", disp_chars, {8{8'h20}});
    check("R10 pins", {62'd0, i2c_scl, i2c_sda}, 64'h3);
    check("R10 req", {63'd0, sys_reset_req}, 64'h0);
    rd("R10 break", 32'h508, 32'h0A);
    rd("R10 gpout", 32'hA00, 32'h0);
    rd("R10 oe", 32'hB08, 32'h0);
    rd("R10 i2cout", 32'hB10, 32'h3);
    rd("R10 sel", 32'hB18, 32'h1);
    // R2 fixed words
    rd("R2 switch", 32'h200, 32'h0);
    rd("R2 status", 32'h208, 32'h12);
    rd("R2 jumper", 32'h210, 32'h0);
    // R3 LED sweep
    for (int v = 0; v < 256; v++) begin
      wr(32'h408, {24'hABCDEF, 8'(v)});
      check("R3 led pin", {56'd0, led_bar}, 64'(v));
      rd("R3 led read", 32'h408, 32'(v));
    end
    // R1 aliasing, idle zero, unmapped
    wr(32'hFFF00408, 32'h5A);
    check("R1 alias write", {56'd0, led_bar}, 64'h5A);
    rd("R1 alias read", 32'h12300408, 32'h5A);
    @(negedge clk);
    check("R1 idle rdata", {32'd0, bus_rdata}, 64'h0);
    wr(32'h40C, 32'hFF);
    wr(32'h600, 32'hFFFFFFFF);
    check("R1 unmapped write led", {56'd0, led_bar}, 64'h5A);
    check("R1 unmapped write disp", disp_chars, {8{8'h20}});
    rd("R1 unmapped read", 32'h40C, 32'h0);
    rd("R1 unmapped read disp", 32'h418, 32'h0);
    // R4 hex word
    foreach (exp_disp[i]) ;
    for (int t = 0; t < 6; t++) begin
      logic [31:0] v;
      v = (t == 0) ? 32'h01234567 : (t == 1) ? 32'h89ABCDEF :
          (t == 2) ? 32'h0 : (t == 3) ? 32'hFFFFFFFF : 32'(t * 32'h1F3A_9C07);
      wr(32'h410, v);
      check("R4 hex word", disp_chars, hexdisp(v));
    end
    // R5 single characters
    exp_disp = disp_chars;
    for (int k = 0; k < 8; k++) begin
      wr(32'h418 + 32'(8 * k), 32'h1100 + 32'(8'h61 + k));
      exp_disp[8*k +: 8] = 8'(8'h61 + k);
      check("R5 char", disp_chars, exp_disp);
    end
    // R6 reset key
    for (int t = 0; t < 6; t++) begin
      logic [31:0] v;
      v = (t < 5) ? 32'(32'h40 + t) : 32'h142;
      wr(32'h500, v);
      check("R6 req", {63'd0, sys_reset_req}, {63'd0, v == 32'h42});
      @(negedge clk);
      check("R6 req drops", {63'd0, sys_reset_req}, 64'h0);
    end
    // R7 scratch registers
    for (int v = 0; v < 256; v += 37) begin
      wr(32'h508, 32'hFFFF0000 | 32'(v));
      rd("R7 break", 32'h508, 32'(v));
      wr(32'hA00, 32'h00FF0000 | 32'(v));
      rd("R7 gpout", 32'hA00, 32'(v));
      wr(32'hB08, 32'(v));
      rd("R7 oe", 32'hB08, 32'(v & 3));
    end
    // R8 I2C output and input
    for (int v = 0; v < 4; v++) begin
      wr(32'hB10, 32'hC0DE0000 | 32'(v));
      check("R8 pins", {62'd0, i2c_scl, i2c_sda}, 64'(v));
      rd("R8 out read", 32'hB10, 32'hC0DE0000 | 32'(v));
    end
    eeprom_sda_in = 1'b0;
    rd("R8 in sda0", 32'hB00, 32'h2);
    eeprom_sda_in = 1'b1;
    rd("R8 in sda1", 32'hB00, 32'h3);
    // R9 select
    rd("R9 sel1", 32'hA08, 32'hC0DE0003);
    wr(32'hB18, 32'hFFFFFFFE);
    rd("R9 sel read", 32'hB18, 32'h0);
    rd("R9 sel0", 32'hA08, 32'h0);
    wr(32'hB18, 32'h1);
    rd("R9 sel back", 32'hA08, 32'hC0DE0003);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule